// File: doc/BRIEF.md
# Energy Peak Phase Lock Controller

This controller finds the phase at which a vibration-driven converter harvests the most energy per cycle. It does so by stepping a delay code and reading back one energy count per reference period. Each count arrives with a one-cycle valid strobe. A sweep covers half a reference period, from code 0 up to the calibration code. While it sweeps, the controller keeps the largest count seen and the delay that produced it.

After the first sweep, the clock polarity output is inverted and the same half period is swept again. The second sweep therefore covers the other half of the period without a longer delay line. The better of the two maxima then fixes the delay code and the polarity, and the controller raises its locked flag. Where the count is low, the sweep takes large strides. Near the peak it moves one code at a time.

Once locked, the controller holds its codes. It inspects only one strobe out of a programmable number of reference periods. If the inspected count falls below the stored peak minus a shifted fraction of that peak, it drops lock and starts a fresh search from the beginning.

Top module: `phase_peak_lock`

## Requirements
- R1: While reset is asserted and at the first clock after it, delay code is 0, polarity is 0 and locked is 0, with the normal-polarity sweep about to begin.
- R2: During a sweep, each strobe at a delay below the calibration code moves the delay forward. The step is 1 when the count is at or above the coarse threshold. It is COARSE_STEP (default 4) when the count is below the threshold. A step that would pass the calibration code stops at the calibration code.
- R3: The strobe taken at delay equal to the calibration code ends the sweep. After the first sweep, the polarity becomes 1 and the delay returns to 0.
- R4: Within each sweep, the recorded peak is the largest count seen, including the count at the last delay. When counts are equal, the earlier delay is kept.
- R5: At the end of the inverted sweep, locked becomes 1. Polarity becomes 1, with the inverted sweep's peak delay, only if that peak is strictly larger than the normal sweep's peak. Otherwise polarity becomes 0 with the normal sweep's peak delay.
- R6: Without a strobe, the delay code, polarity and locked flag do not change.
- R7: While locked, only every (interval+1)-th strobe is inspected, the first being the (interval+1)-th after lock. The strobes in between leave all outputs unchanged, whatever their count.
- R8: An inspected count strictly below peak − (peak >> shift) clears locked, sets delay and polarity to 0, and restarts the search. A count at or above that bound keeps the lock and the codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_cnt | input | ENG_W | Energy count measured for the current delay and polarity |
| eng_vld | input | 1 | One-cycle strobe: eng_cnt is valid |
| cal_code | input | DLY_W | Last delay code of a sweep (half reference period) |
| coarse_thr | input | ENG_W | Counts below this take the coarse step |
| drop_shift | input | SHF_W | Right shift of the peak that sets the relock margin |
| recheck_ivl | input | IVL_W | Strobes skipped between inspections while locked |
| dly_code | output | DLY_W | Delay code applied to the reference clock |
| inv_pol | output | 1 | Reference clock polarity inversion |
| locked | output | 1 | Lock established |

## Verification
The hardest situation to reach is a tie decided across the two sweeps, which requires the search to run all the way through and then restart. The stimulus first locks onto an inverted-sweep peak. It then feeds skipped strobes, an inspected count exactly on the bound, and one count just below it, which forces the controller to drop lock. In the second search, the normal and inverted sweeps both peak at the same count at different delays, which shows both the tie on polarity and the tie on delay. A zero-length sweep (calibration code 0) is run separately after a reset taken while locked.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
   typedef enum logic [1:0] {
      ST_PASS_NORM = 2'd0,
      ST_PASS_INV  = 2'd1,
      ST_HOLD      = 2'd2
   } ppl_state_e;
endpackage

// File: rtl/ppl_step.sv
// Next delay code of a sweep: unit or coarse stride, clamped to the window end.
module ppl_step #(
   parameter int DLY_W       = 8,
   parameter int COARSE_STEP = 4
) (
   input  logic [DLY_W-1:0] cur,
   input  logic [DLY_W-1:0] last,
   input  logic             coarse,
   output logic [DLY_W-1:0] nxt,
   output logic             at_end
);
   localparam logic [DLY_W:0] ONE = (DLY_W+1)'(1);
   localparam logic [DLY_W:0] BIG = (DLY_W+1)'(COARSE_STEP);

   logic [DLY_W:0] stride;
   logic [DLY_W:0] sum;

   generate
      if (COARSE_STEP == 1) begin : g_unit_only
         assign stride = ONE;
         logic unused_coarse;
         assign unused_coarse = coarse;
      end else begin : g_two_rate
         assign stride = coarse ? BIG : ONE;
      end
   endgenerate

   always_comb begin
      sum = {1'b0, cur} + stride;
      if (sum > {1'b0, last}) nxt = last;
      else                    nxt = sum[DLY_W-1:0];
   end

   assign at_end = (cur >= last);
endmodule

// File: rtl/ppl_peak.sv
// Running maximum of one sweep; earlier delay wins on equal counts.
module ppl_peak #(
   parameter int DLY_W = 8,
   parameter int ENG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp,
   input  logic [ENG_W-1:0] cnt,
   input  logic [DLY_W-1:0] dly,
   output logic [ENG_W-1:0] inc_cnt,
   output logic [DLY_W-1:0] inc_dly
);
   logic [ENG_W-1:0] best_cnt;
   logic [DLY_W-1:0] best_dly;
   logic             take;

   assign take    = smp && (cnt > best_cnt);
   assign inc_cnt = take ? cnt : best_cnt;
   assign inc_dly = take ? dly : best_dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_cnt <= '0;
         best_dly <= '0;
      end else if (clr) begin
         best_cnt <= '0;
         best_dly <= '0;
      end else if (smp) begin
         best_cnt <= inc_cnt;
         best_dly <= inc_dly;
      end
   end
endmodule

// File: rtl/ppl_guard.sv
// Post-lock watch: inspects every (ivl+1)-th sample against the peak bound.
module ppl_guard #(
   parameter int ENG_W = 12,
   parameter int SHF_W = 3,
   parameter int IVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [ENG_W-1:0] peak_in,
   input  logic             smp,
   input  logic [ENG_W-1:0] cnt,
   input  logic [SHF_W-1:0] shift,
   input  logic [IVL_W-1:0] ivl,
   output logic             drop
);
   logic [ENG_W-1:0] peak;
   logic [IVL_W-1:0] tick;
   logic [ENG_W-1:0] bound;
   logic             due;

   assign bound = peak - (peak >> shift);
   assign due   = (tick >= ivl);
   assign drop  = smp && due && (cnt < bound);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak <= '0;
         tick <= '0;
      end else if (arm) begin
         peak <= peak_in;
         tick <= '0;
      end else if (smp) begin
         tick <= due ? '0 : tick + 1'b1;
      end
   end
endmodule

// File: rtl/phase_peak_lock.sv
module phase_peak_lock
   import ppl_pkg::*;
#(
   parameter int DLY_W       = 8,
   parameter int ENG_W       = 12,
   parameter int SHF_W       = 3,
   parameter int IVL_W       = 8,
   parameter int COARSE_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ENG_W-1:0] eng_cnt,
   input  logic             eng_vld,
   input  logic [DLY_W-1:0] cal_code,
   input  logic [ENG_W-1:0] coarse_thr,
   input  logic [SHF_W-1:0] drop_shift,
   input  logic [IVL_W-1:0] recheck_ivl,
   output logic [DLY_W-1:0] dly_code,
   output logic             inv_pol,
   output logic             locked
);
   generate
      if (COARSE_STEP < 1 || COARSE_STEP >= (1 << DLY_W)) begin : g_bad_step
         $error("COARSE_STEP must lie in 1 .. 2**DLY_W-1");
      end
      if (SHF_W < 1 || SHF_W > 5) begin : g_bad_shf
         $error("SHF_W must lie in 1 .. 5");
      end
   endgenerate

   ppl_state_e       state;
   logic [ENG_W-1:0] norm_cnt;
   logic [DLY_W-1:0] norm_dly;
   logic [DLY_W-1:0] nxt_dly;
   logic             at_end;
   logic [ENG_W-1:0] inc_cnt;
   logic [DLY_W-1:0] inc_dly;
   logic             sweeping;
   logic             sweep_smp;
   logic             pass_done;
   logic             inv_wins;
   logic             drop;

   assign sweeping  = (state != ST_HOLD);
   assign sweep_smp = eng_vld && sweeping;
   assign pass_done = sweep_smp && at_end;
   assign inv_wins  = (inc_cnt > norm_cnt);
   assign locked    = (state == ST_HOLD);

   ppl_step #(.DLY_W(DLY_W), .COARSE_STEP(COARSE_STEP)) u_step (
      .cur    (dly_code),
      .last   (cal_code),
      .coarse (eng_cnt < coarse_thr),
      .nxt    (nxt_dly),
      .at_end (at_end)
   );

   ppl_peak #(.DLY_W(DLY_W), .ENG_W(ENG_W)) u_peak (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pass_done || drop),
      .smp     (sweep_smp),
      .cnt     (eng_cnt),
      .dly     (dly_code),
      .inc_cnt (inc_cnt),
      .inc_dly (inc_dly)
   );

   ppl_guard #(.ENG_W(ENG_W), .SHF_W(SHF_W), .IVL_W(IVL_W)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (pass_done && state == ST_PASS_INV),
      .peak_in (inv_wins ? inc_cnt : norm_cnt),
      .smp     (eng_vld && locked),
      .cnt     (eng_cnt),
      .shift   (drop_shift),
      .ivl     (recheck_ivl),
      .drop    (drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_PASS_NORM;
         dly_code <= '0;
         inv_pol  <= 1'b0;
         norm_cnt <= '0;
         norm_dly <= '0;
      end else begin
         case (state)
            ST_PASS_NORM: if (eng_vld) begin
               if (at_end) begin
                  norm_cnt <= inc_cnt;
                  norm_dly <= inc_dly;
                  dly_code <= '0;
                  inv_pol  <= 1'b1;
                  state    <= ST_PASS_INV;
               end else begin
                  dly_code <= nxt_dly;
               end
            end
            ST_PASS_INV: if (eng_vld) begin
               if (at_end) begin
                  dly_code <= inv_wins ? inc_dly : norm_dly;
                  inv_pol  <= inv_wins;
                  state    <= ST_HOLD;
               end else begin
                  dly_code <= nxt_dly;
               end
            end
            default: if (drop) begin
               dly_code <= '0;
               inv_pol  <= 1'b0;
               state    <= ST_PASS_NORM;
            end
         endcase
      end
   end
endmodule

// File: rtl/ppl_chk.sv
module ppl_chk #(
   parameter int DLY_W = 8,
   parameter int ENG_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ENG_W-1:0] eng_cnt,
   input logic             eng_vld,
   input logic [DLY_W-1:0] cal_code,
   input logic [ENG_W-1:0] coarse_thr,
   input logic [DLY_W-1:0] dly_code,
   input logic             inv_pol,
   input logic             locked
);
   // R2: a sweep never leaves its window
   a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> dly_code <= cal_code);

   // R2: mid-sweep strobe advances the delay and keeps polarity
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_vld && !locked && dly_code != cal_code)
      |=> (dly_code > $past(dly_code)) && $stable(inv_pol) && !locked);

   // R2: strong count gives the unit step
   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_vld && !locked && dly_code != cal_code && eng_cnt >= coarse_thr)
      |=> dly_code == $past(dly_code) + 1'b1);

   // R5: lock only follows the inverted sweep
   a_r5_lock_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(inv_pol));

   // R6: nothing moves without a strobe
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_vld |=> $stable(dly_code) && $stable(inv_pol) && $stable(locked));

   // R8: losing lock restarts from the normal sweep at delay 0
   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> (dly_code == '0) && !inv_pol);
endmodule

bind phase_peak_lock ppl_chk #(.DLY_W(DLY_W), .ENG_W(ENG_W)) u_ppl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eng_cnt    (eng_cnt),
   .eng_vld    (eng_vld),
   .cal_code   (cal_code),
   .coarse_thr (coarse_thr),
   .dly_code   (dly_code),
   .inv_pol    (inv_pol),
   .locked     (locked)
);

// File: tb/phase_peak_lock_tb_top.sv
`timescale 1ns/1ps
module phase_peak_lock_tb_top;
   localparam int DLY_W = 8;
   localparam int ENG_W = 12;
   localparam int SHF_W = 3;
   localparam int IVL_W = 8;
   localparam int NV    = 25;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [ENG_W-1:0] eng_cnt = '0;
   logic             eng_vld = 1'b0;
   logic [DLY_W-1:0] cal_code = 8'd7;
   logic [ENG_W-1:0] coarse_thr = 12'd100;
   logic [SHF_W-1:0] drop_shift = 3'd2;
   logic [IVL_W-1:0] recheck_ivl = 8'd2;
   logic [DLY_W-1:0] dly_code;
   logic             inv_pol;
   logic             locked;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   phase_peak_lock #(.DLY_W(DLY_W), .ENG_W(ENG_W), .SHF_W(SHF_W),
                     .IVL_W(IVL_W), .COARSE_STEP(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .eng_cnt(eng_cnt), .eng_vld(eng_vld),
      .cal_code(cal_code), .coarse_thr(coarse_thr), .drop_shift(drop_shift),
      .recheck_ivl(recheck_ivl), .dly_code(dly_code), .inv_pol(inv_pol),
      .locked(locked)
   );

   // {count, expected delay, expected polarity, expected locked, requirement}
   // cal 7, threshold 100, coarse step 4, shift 2, interval 2
   localparam logic [25:0] VEC [NV] = '{
      {12'd50,  8'd4, 1'b0, 1'b0, 4'd2},  // R2 coarse stride
      {12'd300, 8'd5, 1'b0, 1'b0, 4'd2},  // R2 unit stride
      {12'd300, 8'd6, 1'b0, 1'b0, 4'd4},  // R4 tie, keep delay 4
      {12'd200, 8'd7, 1'b0, 1'b0, 4'd2},
      {12'd120, 8'd0, 1'b1, 1'b0, 4'd3},  // R3 end of normal sweep
      {12'd20,  8'd4, 1'b1, 1'b0, 4'd2},
      {12'd90,  8'd7, 1'b1, 1'b0, 4'd2},  // R2 clamp 8 -> 7
      {12'd500, 8'd7, 1'b1, 1'b1, 4'd5},  // R5 inverted wins, peak 500
      {12'd0,   8'd7, 1'b1, 1'b1, 4'd7},  // R7 skipped
      {12'd0,   8'd7, 1'b1, 1'b1, 4'd7},  // R7 skipped
      {12'd400, 8'd7, 1'b1, 1'b1, 4'd8},  // R8 inspected, above 375
      {12'd0,   8'd7, 1'b1, 1'b1, 4'd7},
      {12'd0,   8'd7, 1'b1, 1'b1, 4'd7},
      {12'd375, 8'd7, 1'b1, 1'b1, 4'd8},  // R8 exactly on bound
      {12'd0,   8'd7, 1'b1, 1'b1, 4'd7},
      {12'd0,   8'd7, 1'b1, 1'b1, 4'd7},
      {12'd374, 8'd0, 1'b0, 1'b0, 4'd8},  // R8 below bound, relock
      {12'd600, 8'd1, 1'b0, 1'b0, 4'd2},
      {12'd10,  8'd5, 1'b0, 1'b0, 4'd2},
      {12'd10,  8'd7, 1'b0, 1'b0, 4'd2},  // R2 clamp 9 -> 7
      {12'd600, 8'd0, 1'b1, 1'b0, 4'd4},  // R4 tie at last delay, keep 0
      {12'd10,  8'd4, 1'b1, 1'b0, 4'd2},
      {12'd600, 8'd5, 1'b1, 1'b0, 4'd2},
      {12'd10,  8'd7, 1'b1, 1'b0, 4'd2},
      {12'd10,  8'd0, 1'b0, 1'b1, 4'd5}   // R5 equal peaks -> normal pass
   };

   task automatic check(input int req, input logic [DLY_W-1:0] ed,
                        input logic ep, input logic el);
      n_chk++;
      if (dly_code !== ed || inv_pol !== ep || locked !== el) begin
         n_bad++;
         $display("FAIL R%0d: got dly=%0d pol=%0b lock=%0b, expected dly=%0d pol=%0b lock=%0b",
                  req, dly_code, inv_pol, locked, ed, ep, el);
      end
   endtask

   task automatic strobe(input logic [ENG_W-1:0] c);
      @(negedge clk);
      eng_cnt = c;
      eng_vld = 1'b1;
      @(negedge clk);
      eng_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1, 8'd0, 1'b0, 1'b0);            // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 8'd0, 1'b0, 1'b0);            // R1 after release

      for (int i = 0; i < NV; i++) begin
         strobe(VEC[i][25:14]);
         check(int'(VEC[i][3:0]), VEC[i][13:6], VEC[i][5], VEC[i][4]);
      end

      // R6: idle cycles with a big count on the bus change nothing
      eng_cnt = 12'd4000;
      repeat (6) @(negedge clk);
      check(6, 8'd0, 1'b0, 1'b1);

      // R1: reset while locked
      rst_n = 1'b0;
      cal_code = 8'd0;
      @(negedge clk);
      check(1, 8'd0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: one-point sweep ends at once
      strobe(12'd5);
      check(3, 8'd0, 1'b1, 1'b0);
      // R5: inverted 9 beats normal 5
      strobe(12'd9);
      check(5, 8'd0, 1'b1, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule